// File: doc/BRIEF.md
# Grouped DMA Channel Arbiter

This block decides which pending DMA channel is served next. Sixty-four channels sit in four groups of sixteen, and the decision is made in two stages. Inside every group a winner is picked, either by a per-channel priority value or by a descending rotation. Across the groups that have a request, one group is picked, either by a per-group priority value or by a descending rotation. The two stages switch between fixed priority and rotation independently of each other.

The winner is registered. For one cycle it appears as a six-bit channel number together with a valid strobe. A configuration check runs in the same cycle. It looks for priority values that are not unique in whichever stage uses fixed priority. If it finds any while a request is pending, the block reports an error and issues no grant. The rotation pointers move only on a real grant, so an error cycle leaves the rotation where it was.

Top module: `dma_grp_arbiter`

## Requirements
- R1: After reset, and in the cycle after any edge at which no request bit is set, `grantValid` and `cfgError` are both 0.
- R2: Each clock edge at which at least one request is set and no configuration error exists produces a grant. The grant is visible as `grantValid`=1 in the following cycle, with `grantCh` = group*16 + index-in-group. Channel c belongs to group c/16.
- R3: With `chanRrMode`=0, the winner inside a group is the requesting channel whose 4-bit priority, taken from `chanPrio[c*4 +: 4]`, is numerically largest.
- R4: With `chanRrMode`=1, channel priorities are ignored. Each group searches its requesting channels starting at its pointer and counting downward, wrapping from index 0 to index 15.
- R5: With `grpRrMode`=0, the granted group is the requesting group whose 2-bit priority, taken from `grpPrio[g*2 +: 2]`, is numerically largest.
- R6: With `grpRrMode`=1, group priorities are ignored. Groups are searched from the group pointer downward, wrapping from group 0 to group 3.
- R7: On a grant of index i in group g, the channel pointer of group g becomes i-1 and the group pointer becomes g-1, both modulo their size. The pointers of the other groups do not change. This update happens in both modes.
- R8: Reset sets every channel pointer to 15 and the group pointer to 3.
- R9: With `grpRrMode`=0, if two groups hold equal priority values while any request is pending, `cfgError` is 1 and `grantValid` is 0 in the next cycle. With `grpRrMode`=1, equal group priorities cause no error.
- R10: With `chanRrMode`=0, if two channels in the same group hold equal priority values while any request is pending, `cfgError` is 1 and `grantValid` is 0. With `chanRrMode`=1, equal channel priorities cause no error.
- R11: A cycle that raises `cfgError` leaves all rotation pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | 64 | One pending-request bit per channel |
| chanPrio | input | 256 | 4-bit priority per channel, channel c at bits c*4 upward |
| grpPrio | input | 8 | 2-bit priority per group, group g at bits g*2 upward |
| chanRrMode | input | 1 | 1 = rotation inside groups, 0 = fixed channel priority |
| grpRrMode | input | 1 | 1 = rotation across groups, 0 = fixed group priority |
| grantCh | output | 6 | Granted channel number, valid while grantValid is 1 |
| grantValid | output | 1 | One-cycle strobe marking a grant |
| cfgError | output | 1 | Duplicate-priority configuration error |

## Verification
The configuration check and the grant with its pointer advance are decided in the same cycle. The error has to win and freeze the rotation. The bench provokes this by running channel rotation while group priorities hold a duplicate, and by flipping the group mode cycle by cycle so that error cycles and grant cycles interleave. A cycle-accurate model in the bench keeps its own pointers. Every grant after an error must continue the rotation exactly where the last real grant left it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // strobes from control to datapath, one decision per cycle
  typedef struct packed {
    logic issue;   // register a grant and advance the pointers
    logic cfgErr;  // report a configuration error, no grant
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_pick.sv
// One arbitration stage over N candidates: fixed priority or descending rotation.
module dma_arb_pick #(
  parameter int N      = 16,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]        reqIn,
  input  logic [N*PRIO_W-1:0] prioIn,
  input  logic [IDX_W-1:0]    startPtr,
  input  logic                rrMode,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  logic [PRIO_W-1:0] best;
  int p;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    p    = 0;
    if (rrMode) begin
      for (int k = 0; k < N; k++) begin
        p = int'(startPtr) - k;
        if (p < 0) p = p + N;
        if (!hit && reqIn[p]) begin
          hit = 1'b1;
          idx = IDX_W'(p);
        end
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (reqIn[i] && (!hit || prioIn[i*PRIO_W +: PRIO_W] > best)) begin
          hit  = 1'b1;
          idx  = IDX_W'(i);
          best = prioIn[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/dma_arb_ctrl.sv
// Decides per cycle between grant, configuration error and idle.
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int CH_PER_GROUP = 16,
  parameter int CPRI_W       = 4,
  parameter int GPRI_W       = 2,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP
) (
  input  logic [NUM_CH-1:0]            reqVec,
  input  logic [NUM_CH*CPRI_W-1:0]     chanPrio,
  input  logic [NUM_GROUPS*GPRI_W-1:0] grpPrio,
  input  logic                         chanRrMode,
  input  logic                         grpRrMode,
  output arbStrobe_t                   strobe
);
  logic chDup, grDup, anyReq, errNow;

  always_comb begin
    chDup = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++)
      for (int i = 0; i < CH_PER_GROUP; i++)
        for (int j = i + 1; j < CH_PER_GROUP; j++)
          if (chanPrio[(g*CH_PER_GROUP+i)*CPRI_W +: CPRI_W] ==
              chanPrio[(g*CH_PER_GROUP+j)*CPRI_W +: CPRI_W])
            chDup = 1'b1;
  end

  always_comb begin
    grDup = 1'b0;
    for (int i = 0; i < NUM_GROUPS; i++)
      for (int j = i + 1; j < NUM_GROUPS; j++)
        if (grpPrio[i*GPRI_W +: GPRI_W] == grpPrio[j*GPRI_W +: GPRI_W])
          grDup = 1'b1;
  end

  assign anyReq = |reqVec;
  assign errNow = (!chanRrMode && chDup) || (!grpRrMode && grDup);

  always_comb begin
    strobe.issue  = anyReq && !errNow;
    strobe.cfgErr = anyReq && errNow;
  end
endmodule

// File: rtl/dma_arb_datapath.sv
// Two picking stages, rotation pointers and the registered grant.
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int CH_PER_GROUP = 16,
  parameter int CPRI_W       = 4,
  parameter int GPRI_W       = 2,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
  localparam int CIDX_W      = $clog2(CH_PER_GROUP),
  localparam int GIDX_W      = $clog2(NUM_GROUPS),
  localparam int CH_W        = CIDX_W + GIDX_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            reqVec,
  input  logic [NUM_CH*CPRI_W-1:0]     chanPrio,
  input  logic [NUM_GROUPS*GPRI_W-1:0] grpPrio,
  input  logic                         chanRrMode,
  input  logic                         grpRrMode,
  input  arbStrobe_t                   strobe,
  output logic [CH_W-1:0]              grantCh,
  output logic                         grantValid,
  output logic                         cfgError
);
  logic [CIDX_W-1:0] chPtrQ [NUM_GROUPS];
  logic [GIDX_W-1:0] grpPtrQ;
  logic [NUM_GROUPS-1:0] grpHit;
  logic [CIDX_W-1:0] grpIdx [NUM_GROUPS];
  logic [GIDX_W-1:0] winGrp;
  logic [CIDX_W-1:0] winIdx;
  logic              winHit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chan
    dma_arb_pick #(.N(CH_PER_GROUP), .PRIO_W(CPRI_W)) u_pick (
      .reqIn   (reqVec[g*CH_PER_GROUP +: CH_PER_GROUP]),
      .prioIn  (chanPrio[g*CH_PER_GROUP*CPRI_W +: CH_PER_GROUP*CPRI_W]),
      .startPtr(chPtrQ[g]),
      .rrMode  (chanRrMode),
      .hit     (grpHit[g]),
      .idx     (grpIdx[g])
    );
  end

  dma_arb_pick #(.N(NUM_GROUPS), .PRIO_W(GPRI_W)) u_grpPick (
    .reqIn   (grpHit),
    .prioIn  (grpPrio),
    .startPtr(grpPtrQ),
    .rrMode  (grpRrMode),
    .hit     (winHit),
    .idx     (winGrp)
  );

  assign winIdx = grpIdx[winGrp];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      cfgError   <= 1'b0;
      grantCh    <= '0;
      grpPtrQ    <= GIDX_W'(NUM_GROUPS - 1);
      for (int g = 0; g < NUM_GROUPS; g++) chPtrQ[g] <= CIDX_W'(CH_PER_GROUP - 1);
    end else begin
      grantValid <= strobe.issue;
      cfgError   <= strobe.cfgErr;
      if (strobe.issue) begin
        grantCh <= {winGrp, winIdx};
        grpPtrQ <= (winGrp == '0) ? GIDX_W'(NUM_GROUPS - 1) : winGrp - GIDX_W'(1);
        chPtrQ[winGrp] <= (winIdx == '0) ? CIDX_W'(CH_PER_GROUP - 1) : winIdx - CIDX_W'(1);
      end
    end
  end

  // control may only issue when the picking stages found a candidate
  p_issue_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> winHit);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(|reqVec) |=> (!grantValid && !cfgError));

  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !grantValid);

  p_grp_ptr_r7: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grpPtrQ == ((grantCh[CH_W-1:CIDX_W] == '0) ? GIDX_W'(NUM_GROUPS - 1)
                                : grantCh[CH_W-1:CIDX_W] - GIDX_W'(1)));

  p_ch_ptr_r7: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> chPtrQ[grantCh[CH_W-1:CIDX_W]] ==
      ((grantCh[CIDX_W-1:0] == '0) ? CIDX_W'(CH_PER_GROUP - 1) : grantCh[CIDX_W-1:0] - CIDX_W'(1)));

  p_hold_ptr_r11: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> $stable(grpPtrQ));
endmodule

// File: rtl/dma_grp_arbiter.sv
module dma_grp_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_GROUPS   = 4,
  parameter int CH_PER_GROUP = 16,
  parameter int CPRI_W       = 4,
  parameter int GPRI_W       = 2,
  localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            reqVec,
  input  logic [NUM_CH*CPRI_W-1:0]     chanPrio,
  input  logic [NUM_GROUPS*GPRI_W-1:0] grpPrio,
  input  logic                         chanRrMode,
  input  logic                         grpRrMode,
  output logic [CH_W-1:0]              grantCh,
  output logic                         grantValid,
  output logic                         cfgError
);
  arbStrobe_t strobe;

  dma_arb_ctrl #(.NUM_GROUPS(NUM_GROUPS), .CH_PER_GROUP(CH_PER_GROUP),
                 .CPRI_W(CPRI_W), .GPRI_W(GPRI_W)) u_ctrl (
    .reqVec(reqVec), .chanPrio(chanPrio), .grpPrio(grpPrio),
    .chanRrMode(chanRrMode), .grpRrMode(grpRrMode), .strobe(strobe)
  );

  dma_arb_datapath #(.NUM_GROUPS(NUM_GROUPS), .CH_PER_GROUP(CH_PER_GROUP),
                     .CPRI_W(CPRI_W), .GPRI_W(GPRI_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .chanPrio(chanPrio), .grpPrio(grpPrio),
    .chanRrMode(chanRrMode), .grpRrMode(grpRrMode), .strobe(strobe),
    .grantCh(grantCh), .grantValid(grantValid), .cfgError(cfgError)
  );
endmodule

// File: tb/dma_grp_arbiter_tb.sv
`timescale 1ns/1ps
module dma_grp_arbiter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] req = '0;
  logic [255:0] cpri = '0;
  logic [7:0]  gpri = '0;
  logic        chanRr = 1'b0, grpRr = 1'b0;
  logic [5:0]  grantCh;
  logic        grantValid, cfgError;

  int vecs = 0, fails = 0;
  bit done = 1'b0;
  int mCh [4];
  int mGrp;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  dma_grp_arbiter u_dut (
    .clk(clk), .rstN(rstN), .reqVec(req), .chanPrio(cpri), .grpPrio(gpri),
    .chanRrMode(chanRr), .grpRrMode(grpRr),
    .grantCh(grantCh), .grantValid(grantValid), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // reference model written from the requirements; updates its own pointers
  task automatic predict(input logic [63:0] r, output logic eV, output logic eE, output logic [5:0] eC);
    bit gdup = 0, cdup = 0, found;
    int g = 0, i = 0, bestP;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (gpri[a*2 +: 2] == gpri[b*2 +: 2]) gdup = 1;
    for (int q = 0; q < 4; q++)
      for (int a = 0; a < 16; a++)
        for (int b = a + 1; b < 16; b++)
          if (cpri[(q*16+a)*4 +: 4] == cpri[(q*16+b)*4 +: 4]) cdup = 1;
    eE = (r != 0) && ((!grpRr && gdup) || (!chanRr && cdup));
    eV = (r != 0) && !eE;
    eC = '0;
    if (eV) begin
      found = 0; bestP = -1;
      if (grpRr) begin
        for (int k = 0; k < 4; k++) begin
          int c = (mGrp - k + 4) % 4;
          if (!found && r[c*16 +: 16] != 0) begin found = 1; g = c; end
        end
      end else begin
        for (int c = 0; c < 4; c++)
          if (r[c*16 +: 16] != 0 && int'(gpri[c*2 +: 2]) > bestP) begin
            bestP = int'(gpri[c*2 +: 2]); g = c;
          end
      end
      found = 0; bestP = -1;
      if (chanRr) begin
        for (int k = 0; k < 16; k++) begin
          int c = (mCh[g] - k + 16) % 16;
          if (!found && r[g*16 + c]) begin found = 1; i = c; end
        end
      end else begin
        for (int c = 0; c < 16; c++)
          if (r[g*16 + c] && int'(cpri[(g*16+c)*4 +: 4]) > bestP) begin
            bestP = int'(cpri[(g*16+c)*4 +: 4]); i = c;
          end
      end
      eC = 6'(g*16 + i);
      mCh[g] = (i + 15) % 16;
      mGrp   = (g + 3) % 4;
    end
  endtask

  // called at a falling edge: drive, cross one rising edge, sample at the next falling edge
  task automatic step(input logic [63:0] r, input string tag);
    logic eV, eE;
    logic [5:0] eC;
    req = r;
    predict(r, eV, eE, eC);
    @(negedge clk);
    check(grantValid === eV, {tag, " valid"}, 64'(grantValid), 64'(eV));
    check(cfgError === eE, {tag, " cfgError"}, 64'(cfgError), 64'(eE));
    if (eV) check(grantCh === eC, {tag, " grantCh"}, 64'(grantCh), 64'(eC));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    req = '0;
    @(negedge clk);
    check(grantValid === 1'b0 && cfgError === 1'b0, "R1 reset state",
          64'({grantValid, cfgError}), 64'(0));
    for (int q = 0; q < 4; q++) mCh[q] = 15;  // R8
    mGrp = 3;
    rstN = 1'b1;
  endtask

  task automatic setPrios();
    for (int c = 0; c < 64; c++) cpri[c*4 +: 4] = 4'(((c % 16) * 7 + 3) % 16);
    for (int q = 0; q < 4; q++) gpri[q*2 +: 2] = 2'((q * 3 + 1) % 4);
  endtask

  task automatic randRun(input int n, input bit sparse, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [63:0] a;
      lfsr = nextRand(lfsr); a = lfsr;
      lfsr = nextRand(lfsr);
      step(sparse ? (a & lfsr & nextRand(lfsr)) : a, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    setPrios();
    doReset();
    step('0, "R1 idle");

    // fixed priority at both stages
    for (int c = 0; c < 64; c++) step(64'(1) << c, "R2 R3 R5 single request");
    randRun(200, 0, "R3 R5 fixed dense");
    randRun(200, 1, "R3 R5 fixed sparse");
    step('0, "R1 idle after grants");

    // rotation at both stages, starting from reset pointers
    doReset();
    chanRr = 1; grpRr = 1;
    step('1, "R8 first search from top");
    for (int k = 0; k < 80; k++) step('1, "R4 R6 R7 full rotation");
    randRun(300, 0, "R4 R6 rotation dense");
    randRun(300, 1, "R4 R6 rotation sparse");

    // mixed modes; pointers carry over
    chanRr = 1; grpRr = 0;
    randRun(150, 1, "R4 R5 R7 mixed");
    chanRr = 0; grpRr = 1;
    randRun(150, 1, "R3 R6 R7 mixed");

    // duplicate group priorities
    gpri[2*2 +: 2] = gpri[0 +: 2];
    chanRr = 0; grpRr = 0;
    step('0, "R1 R9 duplicate but idle");
    randRun(20, 0, "R9 group duplicate error");
    grpRr = 1;
    randRun(20, 1, "R9 group duplicate ignored in rotation");

    // error interleaved with channel rotation: pointers must freeze
    chanRr = 1;
    for (int k = 0; k < 120; k++) begin
      lfsr = nextRand(lfsr);
      grpRr = lfsr[63];
      step(lfsr[0] ? '1 : nextRand(lfsr), "R11 error freezes rotation");
    end

    // duplicate channel priorities inside group 0
    setPrios();
    cpri[6*4 +: 4] = cpri[5*4 +: 4];
    chanRr = 0; grpRr = 0;
    randRun(20, 0, "R10 channel duplicate error");
    step(64'h0000_0000_0001_0000, "R10 duplicate in other group still errors");
    chanRr = 1;
    randRun(20, 1, "R10 channel duplicate ignored in rotation");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule